// File: doc/BRIEF.md
# Configurable Test Pixel Pattern Generator

The block produces one 16-bit test pixel for every sample strobe so that a downstream digital data path can be exercised with a known pattern. The pixel is assembled in layers from static configuration inputs. The base layer is a 16-bit up/down counter. A 3-bit pseudo-random field can replace the three low bits. A fixed 4-bit value can replace the top nibble. A single selected bit can be pinned to 0 or 1, and this pinned bit overrides every other layer.

The strobe is active low and asynchronous to the system clock. It is synchronised inside the block, and its falling edge advances the counter and the noise source. No reset line reaches the block between frames. An optional idle timer therefore clears the counter after a quiet gap of two or four seconds, so the next frame starts at zero. One input has two meanings. With bit pinning off, it sets the count direction. With bit pinning on, it sets the pinned value, and the last direction chosen stays in force.

Top module: `test_pixel_gen`

## Requirements
- R1: With the counter enabled and direction 0 (up), each strobe falling edge adds one to the counter, wrapping 0xFFFF to 0x0000.
- R2: With the counter enabled and direction 1 (down), each strobe falling edge subtracts one, wrapping 0x0000 to 0xFFFF.
- R3: With the counter disabled, strobes leave the counter bits of the pixel unchanged.
- R4: With noise enabled, pixel bits [2:0] equal bits [2:0] of a 16-bit LFSR (shift left, feedback = bit15^bit13^bit12^bit10, seed 0xACE1 at reset) that steps once per strobe whether or not noise or the counter is enabled; bits [15:3] are unaffected by noise.
- R5: With offset enabled, pixel bits [15:12] equal the 4-bit offset input, overriding counter and noise.
- R6: With pin enabled, pixel bit number pin_idx_i (0 to 15) equals dir_pol_i, overriding counter, noise and offset; all other bits are as without pinning.
- R7: While pin is enabled, dir_pol_i does not alter the count direction; the direction last set with pin disabled stays in use.
- R8: With self-clear enabled and select 0, the counter clears to 0 once 2*CLK_HZ clock cycles pass with no strobe edge; earlier than that it keeps its value, and the next strobe counts from 0.
- R9: With self-clear enabled and select 1, the clear happens after 4*CLK_HZ idle cycles instead; the value is still held at 2*CLK_HZ.
- R10: With self-clear disabled, the counter never clears on idleness.
- R11: A strobe held low for several cycles advances the counter exactly once; the strobe passes through two synchroniser flops and the pixel output is registered.
- R12: After reset the pixel is 0x0000, the counter is 0 and the direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_ni | input | 1 | Active-low sample strobe, asynchronous |
| cnt_en_i | input | 1 | Counter advance enable |
| dir_pol_i | input | 1 | Count direction (pin off) or pinned value (pin on) |
| noise_en_i | input | 1 | Replace bits [2:0] with noise |
| ofs_en_i | input | 1 | Replace bits [15:12] with offset |
| ofs_val_i | input | 4 | Offset nibble |
| pin_en_i | input | 1 | Pin one bit to dir_pol_i |
| pin_idx_i | input | 4 | Index of the pinned bit |
| idle_clr_en_i | input | 1 | Enable idle self-clear of the counter |
| idle_long_i | input | 1 | Idle interval select: 0 = 2 s, 1 = 4 s |
| pixel_o | output | 16 | Registered pixel |

## Verification
A strobe falling edge reaches the counter and LFSR on the third clock edge after the strobe is first sampled low, and the pixel register shows the result on the fourth edge. The bench holds each strobe low for four cycles and high for four more, then samples on a falling clock edge, so every count, wrap and noise value is read after it has settled. A configuration change alone reaches the pixel one edge later, so the pin and offset sweeps wait two cycles per setting. The idle clear comes its full interval after the detected edge, plus one cycle for the clear pulse and one for the output register. With a scaled clock rate, the bench samples well inside the window before and well after that point.

// File: rtl/pxg_pkg.sv
package pxg_pkg;
  localparam int unsigned PIX_W   = 16;
  localparam int unsigned OFS_W   = 4;
  localparam int unsigned NOISE_W = 3;
  localparam int unsigned IDX_W   = $clog2(PIX_W);
  localparam logic [PIX_W-1:0] LFSR_SEED = 16'hACE1;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= strobe_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;

  // R11: a single edge never spans two cycles
  a_r11_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pixel_counter.sv
module pixel_counter
  import pxg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic down_i,
  output pix_t cnt_o
);
  pix_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_i && en_i)    cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r1_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && en_i && !down_i && !clr_i) |=> cnt_o == pix_t'($past(cnt_o) + 1'b1));
  a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && en_i && down_i && !clr_i) |=> cnt_o == pix_t'($past(cnt_o) - 1'b1));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(step_i && en_i) && !clr_i) |=> $stable(cnt_o));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import pxg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  output logic [NOISE_W-1:0] noise_o
);
  pix_t lfsr_q;
  logic fb;

  assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= LFSR_SEED;
    else if (step_i)  lfsr_q <= {lfsr_q[PIX_W-2:0], fb};
  end

  assign noise_o = lfsr_q[NOISE_W-1:0];

  // R4: state must never lock up at zero
  a_r4_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SHORT_S = 2,
  parameter int unsigned LONG_S  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic en_i,
  input  logic long_i,
  output logic clr_o
);
  localparam int unsigned LONG_CYC  = LONG_S * CLK_HZ;
  localparam int unsigned SHORT_CYC = SHORT_S * CLK_HZ;
  localparam int unsigned TW        = $clog2(LONG_CYC + 1);
  localparam logic [TW-1:0] SHORT_LIM = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_LIM  = TW'(LONG_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic          done_q, clr_q;
  logic [TW-1:0] lim;

  assign lim = long_i ? LONG_LIM : SHORT_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (kick_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (cnt_q >= lim) begin
          done_q <= 1'b1;
          clr_q  <= en_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign clr_o = clr_q;

  a_r8_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);
  a_r10_no_clear_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !clr_o);
endmodule

// File: rtl/test_pixel_gen.sv
module test_pixel_gen
  import pxg_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SHORT_S = 2,
  parameter int unsigned LONG_S  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_ni,
  input  logic             cnt_en_i,
  input  logic             dir_pol_i,
  input  logic             noise_en_i,
  input  logic             ofs_en_i,
  input  logic [OFS_W-1:0] ofs_val_i,
  input  logic             pin_en_i,
  input  logic [IDX_W-1:0] pin_idx_i,
  input  logic             idle_clr_en_i,
  input  logic             idle_long_i,
  output logic [PIX_W-1:0] pixel_o
);
  logic               edge_s, clr_s, dir_q, down_s, init_q;
  pix_t               cnt_s, pix_d, pix_q, pin_mask;
  logic [NOISE_W-1:0] noise_s;

  strobe_sync u_sync (
    .clk_i, .rst_ni, .strobe_ni(sample_ni), .fall_o(edge_s)
  );

  // direction is latched only while the shared input means direction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dir_q <= 1'b0;
    else if (!pin_en_i) dir_q <= dir_pol_i;
  end
  assign down_s = pin_en_i ? dir_q : dir_pol_i;

  pixel_counter u_cnt (
    .clk_i, .rst_ni, .step_i(edge_s), .clr_i(clr_s),
    .en_i(cnt_en_i), .down_i(down_s), .cnt_o(cnt_s)
  );

  noise_lfsr u_lfsr (
    .clk_i, .rst_ni, .step_i(edge_s), .noise_o(noise_s)
  );

  idle_timer #(.CLK_HZ(CLK_HZ), .SHORT_S(SHORT_S), .LONG_S(LONG_S)) u_idle (
    .clk_i, .rst_ni, .kick_i(edge_s), .en_i(idle_clr_en_i),
    .long_i(idle_long_i), .clr_o(clr_s)
  );

  // 4-to-16 decode of the pinned bit
  for (genvar b = 0; b < PIX_W; b++) begin : g_dec
    assign pin_mask[b] = pin_en_i && (pin_idx_i == IDX_W'(b));
  end

  // precedence: pin > offset > noise > counter
  always_comb begin
    pix_d = cnt_s;
    if (noise_en_i) pix_d[NOISE_W-1:0] = noise_s;
    if (ofs_en_i)   pix_d[PIX_W-1 -: OFS_W] = ofs_val_i;
    pix_d = (pix_d & ~pin_mask) | (dir_pol_i ? pin_mask : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      init_q <= 1'b0;
    end else begin
      pix_q  <= pix_d;
      init_q <= 1'b1;
    end
  end

  assign pixel_o = pix_q;

  a_r6_pinned_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && $past(pin_en_i)) |-> pixel_o[$past(pin_idx_i)] == $past(dir_pol_i));
  a_r5_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && $past(ofs_en_i) && !$past(pin_en_i))
      |-> pixel_o[PIX_W-1 -: OFS_W] == $past(ofs_val_i));
  a_r7_dir_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_en_i |=> dir_q == $past(dir_q));
endmodule

// File: tb/test_pixel_gen_tb_top.sv
`timescale 1ns/1ps
module test_pixel_gen_tb_top;
  localparam int unsigned CLK_HZ = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_n = 1'b1;
  logic        cnt_en = 1'b0, dir_pol = 1'b0, noise_en = 1'b0, ofs_en = 1'b0;
  logic [3:0]  ofs_val = '0, pin_idx = '0;
  logic        pin_en = 1'b0, idle_en = 1'b0, idle_long = 1'b0;
  logic [15:0] pixel;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_cnt, m_lfsr;
  logic        m_dir;

  always #5 clk = ~clk;

  test_pixel_gen #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_ni(sample_n), .cnt_en_i(cnt_en),
    .dir_pol_i(dir_pol), .noise_en_i(noise_en), .ofs_en_i(ofs_en),
    .ofs_val_i(ofs_val), .pin_en_i(pin_en), .pin_idx_i(pin_idx),
    .idle_clr_en_i(idle_en), .idle_long_i(idle_long), .pixel_o(pixel)
  );

  function automatic logic [15:0] exp_pix();
    logic [15:0] p = m_cnt;
    if (noise_en) p[2:0] = m_lfsr[2:0];
    if (ofs_en)   p[15:12] = ofs_val;
    if (pin_en)   p[pin_idx] = dir_pol;
    return p;
  endfunction

  task automatic chk(string req, logic [15:0] exp);
    checks++;
    if (pixel !== exp) begin
      errors++;
      $display("FAIL %s: pixel=%h expected=%h", req, pixel, exp);
    end
  endtask

  // one strobe; model advances by the requirements
  task automatic strobe();
    @(negedge clk) sample_n = 1'b0;
    repeat (4) @(negedge clk);
    sample_n = 1'b1;
    repeat (4) @(negedge clk);
    if (!pin_en) m_dir = dir_pol;
    if (cnt_en) m_cnt = m_dir ? m_cnt - 16'd1 : m_cnt + 16'd1;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    m_cnt = '0; m_lfsr = 16'hACE1; m_dir = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset", 16'h0000);

    // R2 down wrap from zero
    cnt_en = 1'b1; dir_pol = 1'b1;
    for (int i = 0; i < 3; i++) begin strobe(); chk("R2 down", exp_pix()); end
    if (m_cnt !== 16'hFFFD) begin errors++; $display("FAIL R2: model=%h expected=fffd", m_cnt); end
    // R1 up wrap through 0xFFFF
    dir_pol = 1'b0;
    for (int i = 0; i < 5; i++) begin strobe(); chk("R1 up", exp_pix()); end
    chk("R1 wrap end", 16'h0002);

    // R3 disabled holds; R11 long strobe counts once (already 4-cycle low)
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin strobe(); chk("R3 hold", 16'h0002); end
    cnt_en = 1'b1;
    strobe(); chk("R11 single advance", 16'h0003);

    // R4 noise, counter off then on
    noise_en = 1'b1; cnt_en = 1'b0;
    for (int i = 0; i < 4; i++) begin strobe(); chk("R4 noise hold", exp_pix()); end
    cnt_en = 1'b1;
    for (int i = 0; i < 4; i++) begin strobe(); chk("R4 noise count", exp_pix()); end

    // R5 offset
    ofs_en = 1'b1; ofs_val = 4'hA;
    for (int i = 0; i < 2; i++) begin strobe(); chk("R5 offset", exp_pix()); end
    for (int v = 0; v < 16; v++) begin
      ofs_val = 4'(v);
      repeat (2) @(negedge clk);
      chk("R5 offset sweep", exp_pix());
    end

    // R6 pin sweep over every index and both values
    pin_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 2; p++) begin
        pin_idx = 4'(i); dir_pol = 1'(p);
        repeat (2) @(negedge clk);
        chk("R6 pin", exp_pix());
      end
    end

    // R7 pin value 1 must not turn the count downward
    pin_idx = 4'd15; dir_pol = 1'b1; noise_en = 1'b0; ofs_en = 1'b0;
    for (int i = 0; i < 3; i++) begin strobe(); chk("R7 dir kept", exp_pix()); end
    pin_en = 1'b0;
    strobe(); chk("R7 dir down after unpin", exp_pix());
    dir_pol = 1'b0;
    strobe(); chk("R7 dir up", exp_pix());

    // R10 no self-clear when disabled
    repeat (100) @(negedge clk);
    chk("R10 no clear", exp_pix());

    // R8 short interval (20 cycles)
    idle_en = 1'b1; idle_long = 1'b0;
    strobe();
    repeat (5) @(negedge clk);
    chk("R8 before limit", exp_pix());
    repeat (30) @(negedge clk);
    m_cnt = '0;
    chk("R8 cleared", 16'h0000);
    strobe(); chk("R8 restart from zero", 16'h0001);

    // R9 long interval (40 cycles)
    idle_long = 1'b1;
    strobe();
    repeat (20) @(negedge clk);
    chk("R9 held past short limit", 16'h0002);
    repeat (40) @(negedge clk);
    m_cnt = '0;
    chk("R9 cleared", 16'h0000);

    finish_run();
  end
endmodule